// File: doc/BRIEF.md
# Serial Byte-Memory Slave Controller

This block is the command engine of a serial byte-wide memory that answers as a mode-0 SPI slave. The SPI pins are oversampled by the system clock. The block decodes an 8-bit opcode after chip select falls. It then reads the array with an auto-incrementing address, reads or writes a status byte, or takes write data into a page buffer. A write or status update is committed only when chip select rises, and only if a write-enable latch was armed beforehand by a separate command.

After a commit the block reports busy for a fixed number of clock cycles. During that time it honours only the status read. Two protection bits in the status byte lock the upper quarter, the upper half or the whole of the array against writes. Reads stay unaffected. A hold input freezes the transfer mid-bit and floats the serial output. The array depth, page size, busy length and synchroniser depth are parameters.

Top module: `spi_ee_ctrl`

## Requirements
- R1: SI is taken on rising SCK while cs_n is low, most significant bit first. The first byte of a frame is the opcode. Its upper nibble must be 0000, or the frame is ignored, and bit 3 is a don't-care. The low three bits select the command: 110 arm latch, 100 disarm latch, 101 status read, 001 status write, 011 array read, 010 array write.
- R2: so_oe is low while cs_n is high, while opcode and address bits are shifted, and while hold_n is low. It is high only during status or array read data.
- R3: An array read takes a 16-bit address, most significant byte first, and keeps only its low ADDR_W bits. It returns bytes MSB first. The address increments after each byte and wraps from the last location to 0.
- R4: The status byte reads as bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bits 7:4 zero. It is reloaded live for every further byte clocked in the same frame.
- R5: Opcode 110 sets the write-enable latch and opcode 100 clears it.
- R6: An array write or status write issued while the latch is clear changes neither the array nor the status.
- R7: A write commits when cs_n rises, and only if at least one whole data byte arrived and no partial byte follows. Otherwise nothing is written and the latch keeps its state.
- R8: Write data fills a page of 2**PAGE_W bytes. The low address bits wrap inside the page, and a later byte for the same location replaces an earlier one.
- R9: A commit clears the write-enable latch and sets busy for WR_CYCLES clock cycles.
- R10: While busy, every opcode except status read is ignored: the latch is not armed and no read data is driven.
- R11: Protection level 00 protects nothing, 01 protects the top quarter of the address space, 10 the top half and 11 all of it. Writes to protected bytes are dropped, while reads of them work.
- R12: While hold_n is low, SCK and SI are ignored and the transfer resumes at the same bit once hold_n returns high.
- R13: A status write stores only bits 3:2 of its data byte, into the protection level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select, frames one command |
| si | input | 1 | Serial data from the master |
| hold_n | input | 1 | Active-low pause of the current transfer |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Output enable for so; low means high impedance |

## Verification
The hardest states to reach are the commands that arrive during the busy window after a commit. The bench issues them in the frame right after the committing frame, well inside WR_CYCLES. It then checks that a read drives nothing and that an arm command leaves the latch clear once busy has ended. Partial-byte writes, page wrap-around and hold pauses within a read byte are built from a bit-level transfer task, and each is followed by a readback that exposes the array and status state.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [2:0] {
      OP_WRSR  = 3'b001,
      OP_WRITE = 3'b010,
      OP_READ  = 3'b011,
      OP_WRDI  = 3'b100,
      OP_RDSR  = 3'b101,
      OP_WREN  = 3'b110
   } op_e;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_RDATA,
      ST_WDATA,
      ST_RSR,
      ST_WSR,
      ST_SKIP
   } st_e;

   function automatic logic [7:0] pack_status(input logic [1:0] lvl,
                                              input logic wel,
                                              input logic busy);
      return {4'b0000, lvl, wel, busy};
   endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_ee_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_ee_prot.sv
module spi_ee_prot #(
   parameter int AW = 10
) (
   input  logic [1:0]    level,
   input  logic [AW-1:0] addr,
   output logic          hit
);
   if (AW < 2) begin : g_bad_aw
      $error("spi_ee_prot: AW must be at least 2");
   end

   always_comb begin
      case (level)
         2'b00:   hit = 1'b0;
         2'b01:   hit = &addr[AW-1 -: 2];
         2'b10:   hit = addr[AW-1];
         default: hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl #(
   parameter int ADDR_W      = 10,
   parameter int PAGE_W      = 3,
   parameter int WR_CYCLES   = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   input  logic hold_n,
   output logic so,
   output logic so_oe
);
   import spi_ee_pkg::*;

   localparam int PAGE  = 1 << PAGE_W;
   localparam int BASE_W = ADDR_W - PAGE_W;
   localparam int CNT_W = $clog2(WR_CYCLES + 1);

   if (ADDR_W > 16 || ADDR_W < PAGE_W + 2) begin : g_bad_addr
      $error("spi_ee_ctrl: ADDR_W must be in PAGE_W+2 .. 16");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("spi_ee_ctrl: PAGE_W must be at least 1");
   end
   if (WR_CYCLES < PAGE) begin : g_bad_busy
      $error("spi_ee_ctrl: WR_CYCLES must cover one page commit");
   end

   // ---------------- pin synchronisers and edge detect ----------------
   logic [3:0] pins_q;
   logic cs_s, sck_s, si_s, hold_s, sck_d, cs_d;

   spi_ee_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hold_n, si, sck, cs_n}),
      .q     (pins_q)
   );
   assign {hold_s, si_s, sck_s, cs_s} = pins_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         cs_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
      end
   end

   logic sck_rise, cs_rise, edge_v;
   assign sck_rise = sck_s & ~sck_d;
   assign cs_rise  = cs_s & ~cs_d;
   assign edge_v   = sck_rise & ~cs_s & hold_s;

   // ---------------- frame state ----------------
   st_e               st;
   logic [3:0]        bit_cnt;
   logic [15:0]       sr;
   logic [15:0]       nxt;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        out_sr;
   logic              is_wr;
   logic              wsr_got;
   logic [7:0]        wsr_val;
   logic              wel, busy;
   logic [1:0]        bp;
   logic [CNT_W-1:0]  busy_cnt;
   op_e               op;
   logic [7:0]        status;

   assign nxt    = {sr[14:0], si_s};
   assign op     = op_e'(nxt[2:0]);
   assign status = pack_status(bp, wel, busy);

   // ---------------- page buffer and commit engine ----------------
   logic [7:0]        pbuf [PAGE];
   logic [PAGE-1:0]   pvld;
   logic [BASE_W-1:0] pbase;
   logic              committing;
   logic [PAGE_W-1:0] cm_idx;
   logic [ADDR_W-1:0] cm_addr;
   logic              cm_prot;
   logic              arr_we;
   logic              pb_we;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;

   assign cm_addr = {pbase, cm_idx};
   assign arr_we  = committing & pvld[cm_idx] & ~cm_prot;
   assign pb_we   = edge_v && (st == ST_WDATA) && (bit_cnt == 4'd7);
   assign rd_addr = (st == ST_ADDR) ? nxt[ADDR_W-1:0] : ADDR_W'(addr + 1'b1);

   spi_ee_prot #(.AW(ADDR_W)) u_prot (
      .level (bp),
      .addr  (cm_addr),
      .hit   (cm_prot)
   );

   spi_ee_array #(.AW(ADDR_W), .DW(8)) u_array (
      .clk   (clk),
      .we    (arr_we),
      .waddr (cm_addr),
      .wdata (pbuf[cm_idx]),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (pb_we) pbuf[addr[PAGE_W-1:0]] <= nxt[7:0];
   end

   // ---------------- main control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_CMD;
         bit_cnt    <= '0;
         sr         <= '0;
         addr       <= '0;
         out_sr     <= '0;
         is_wr      <= 1'b0;
         wsr_got    <= 1'b0;
         wsr_val    <= '0;
         wel        <= 1'b0;
         busy       <= 1'b0;
         bp         <= 2'b00;
         busy_cnt   <= '0;
         pvld       <= '0;
         pbase      <= '0;
         committing <= 1'b0;
         cm_idx     <= '0;
      end else begin
         if (busy) begin
            if (busy_cnt == '0) busy <= 1'b0;
            else busy_cnt <= busy_cnt - 1'b1;
         end
         if (committing) begin
            cm_idx <= cm_idx + 1'b1;
            if (cm_idx == PAGE_W'(PAGE - 1)) committing <= 1'b0;
         end

         if (cs_s) begin
            st      <= ST_CMD;
            bit_cnt <= '0;
            if (cs_rise && bit_cnt == 4'd0) begin
               if (st == ST_WDATA && |pvld) begin
                  wel        <= 1'b0;
                  busy       <= 1'b1;
                  busy_cnt   <= CNT_W'(WR_CYCLES - 1);
                  committing <= 1'b1;
                  cm_idx     <= '0;
               end else if (st == ST_WSR && wsr_got) begin
                  bp       <= wsr_val[3:2];
                  wel      <= 1'b0;
                  busy     <= 1'b1;
                  busy_cnt <= CNT_W'(WR_CYCLES - 1);
               end
            end
         end else if (edge_v) begin
            sr <= nxt;
            case (st)
               ST_CMD: begin
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     if (nxt[7:4] != 4'b0000 || (busy && op != OP_RDSR)) begin
                        st <= ST_SKIP;
                     end else begin
                        case (op)
                           OP_WREN: begin wel <= 1'b1; st <= ST_SKIP; end
                           OP_WRDI: begin wel <= 1'b0; st <= ST_SKIP; end
                           OP_RDSR: begin out_sr <= status; st <= ST_RSR; end
                           OP_WRSR: begin
                              wsr_got <= 1'b0;
                              st      <= wel ? ST_WSR : ST_SKIP;
                           end
                           OP_READ: begin is_wr <= 1'b0; st <= ST_ADDR; end
                           OP_WRITE: begin
                              is_wr <= 1'b1;
                              st    <= wel ? ST_ADDR : ST_SKIP;
                           end
                           default: st <= ST_SKIP;
                        endcase
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_ADDR: begin
                  if (bit_cnt == 4'd15) begin
                     bit_cnt <= '0;
                     addr    <= nxt[ADDR_W-1:0];
                     if (is_wr) begin
                        pvld  <= '0;
                        pbase <= nxt[ADDR_W-1:PAGE_W];
                        st    <= ST_WDATA;
                     end else begin
                        out_sr <= rd_data;
                        st     <= ST_RDATA;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_RDATA: begin
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     addr    <= rd_addr;
                     out_sr  <= rd_data;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     out_sr  <= {out_sr[6:0], 1'b0};
                  end
               end
               ST_RSR: begin
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     out_sr  <= status;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     out_sr  <= {out_sr[6:0], 1'b0};
                  end
               end
               ST_WDATA: begin
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     pvld[addr[PAGE_W-1:0]] <= 1'b1;
                     addr <= {addr[ADDR_W-1:PAGE_W], PAGE_W'(addr[PAGE_W-1:0] + 1'b1)};
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_WSR: begin
                  if (bit_cnt == 4'd7) begin
                     bit_cnt <= '0;
                     wsr_val <= nxt[7:0];
                     wsr_got <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign so    = out_sr[7];
   assign so_oe = (st == ST_RDATA || st == ST_RSR) && !cs_s && hold_s;

   // ---------------- assertions ----------------
   a_r9_commit_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(committing) |-> $past(wel));

   a_r9_commit_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
      committing |-> busy);

   a_r10_no_arm_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> !$past(busy));

   a_r7_busy_starts_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_s));

   a_r11_level_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bp));

   a_r12_hold_freezes_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && !hold_s) |=> ($stable(bit_cnt) && $stable(st)));
endmodule

// File: tb/spi_ee_ctrl_tb.sv
module spi_ee_ctrl_tb;
   localparam int ADDR_W = 10;
   localparam int PAGE_W = 3;
   localparam int WR_CYC = 400;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PAGE   = 1 << PAGE_W;
   localparam int HALF   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic so, so_oe;

   always #10 clk = ~clk;

   spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .hold_n(hold_n), .so(so), .so_oe(so_oe)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // behavioural reference state
   int  m_mem [DEPTH];
   int  m_lvl = 0;
   bit  m_wel = 1'b0;
   bit  m_busy = 1'b0;

   function automatic bit m_locked(int a);
      case (m_lvl)
         1: return a >= (DEPTH * 3) / 4;
         2: return a >= DEPTH / 2;
         3: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int m_status();
      return (m_lvl << 2) | (int'(m_wel) << 1) | int'(m_busy);
   endfunction

   task automatic chk(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_open();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic frame_close();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
      chk("R2 so_oe with cs_n high", int'(so_oe), 0);
   endtask

   // transfer nb bits of tx, MSB first; optional hold pause before bit hold_at
   task automatic xfer(input logic [7:0] tx, input int nb, input int hold_at,
                       output logic [7:0] rx, output bit oe_any, output bit oe_all);
      rx = '0; oe_any = 1'b0; oe_all = 1'b1;
      for (int i = 0; i < nb; i++) begin
         si = tx[7-i];
         if (i == hold_at) begin
            hold_n = 1'b0;
            wait_clk(HALF);
            for (int k = 0; k < 3; k++) begin
               sck = 1'b1; si = ~si; wait_clk(4);
               sck = 1'b0; wait_clk(4);
            end
            chk("R12 so_oe during hold", int'(so_oe), 0);
            chk("R2 so_oe during hold", int'(so_oe), 0);
            si = tx[7-i];
            hold_n = 1'b1;
         end
         wait_clk(HALF);
         rx[7-i] = so;
         oe_any |= so_oe;
         oe_all &= so_oe;
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic send_hdr(logic [7:0] code, string req);
      logic [7:0] rx; bit a, b;
      xfer(code, 8, -1, rx, a, b);
      chk({req, " so_oe during opcode"}, int'(a), 0);
   endtask

   task automatic send_addr(int a);
      logic [7:0] rx; bit x, y, x2;
      xfer(8'(a >> 8), 8, -1, rx, x, y);
      xfer(8'(a), 8, -1, rx, x2, y);
      chk("R2 so_oe during address", int'(x | x2), 0);
   endtask

   task automatic simple_op(logic [7:0] code, string req);
      frame_open();
      send_hdr(code, req);
      frame_close();
      if (!m_busy && code[7:4] == 4'h0) begin
         if (code[2:0] == 3'b110) m_wel = 1'b1;
         if (code[2:0] == 3'b100) m_wel = 1'b0;
      end
   endtask

   task automatic rdsr(int nrep, string req);
      logic [7:0] rx; bit a, b;
      frame_open();
      send_hdr(8'h05, "R2");
      for (int r = 0; r < nrep; r++) begin
         xfer(8'h00, 8, -1, rx, a, b);
         chk({req, " status byte"}, int'(rx), m_status());
         chk("R2 so_oe during status data", int'(b), 1);
      end
      frame_close();
   endtask

   task automatic rd(int a, int n, int hold_byte, string req);
      logic [7:0] rx; bit x, y;
      frame_open();
      send_hdr(8'h03, "R2");
      send_addr(a);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, 8, (k == hold_byte) ? 3 : -1, rx, x, y);
         chk({req, " read data"}, int'(rx), m_mem[((a % DEPTH) + k) % DEPTH]);
         chk("R2 so_oe during read data", int'(y), 1);
      end
      frame_close();
   endtask

   task automatic rd_busy();
      logic [7:0] rx; bit x, y, z;
      frame_open();
      send_hdr(8'h03, "R10");
      send_addr(16'h0010);
      xfer(8'h00, 8, -1, rx, x, y);
      xfer(8'h00, 8, -1, rx, z, y);
      chk("R10 read while busy drives nothing", int'(x | z), 0);
      frame_close();
   endtask

   // write n bytes (start + i*step) then extra partial bits
   task automatic wr(int a, int n, int start, int step, int extra);
      logic [7:0] rx; bit x, y;
      frame_open();
      send_hdr(8'h02, "R2");
      send_addr(a);
      for (int i = 0; i < n; i++) xfer(8'((start + i * step) & 255), 8, -1, rx, x, y);
      if (extra > 0) xfer(8'hA5, extra, -1, rx, x, y);
      frame_close();
      if (m_wel && !m_busy && extra == 0 && n > 0) begin
         int base = (a % DEPTH) - ((a % DEPTH) % PAGE);
         int lo = a % PAGE;
         for (int i = 0; i < n; i++) begin
            int t = base + ((lo + i) % PAGE);
            if (!m_locked(t)) m_mem[t] = (start + i * step) & 255;
         end
         m_wel = 1'b0;
         m_busy = 1'b1;
      end
   endtask

   task automatic wrsr(logic [7:0] val);
      logic [7:0] rx; bit x, y;
      frame_open();
      send_hdr(8'h01, "R2");
      xfer(val, 8, -1, rx, x, y);
      frame_close();
      if (m_wel && !m_busy) begin
         m_lvl = int'(val[3:2]);
         m_wel = 1'b0;
         m_busy = 1'b1;
      end
   endtask

   task automatic wait_idle();
      wait_clk(WR_CYC + 40);
      m_busy = 1'b0;
   endtask

   task automatic arm_write(int a, int n, int start, int step);
      simple_op(8'h06, "R5");
      wr(a, n, start, step, 0);
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired before the sequence completed");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      chk("R2 so_oe after reset", int'(so_oe), 0);
      rdsr(1, "R4 reset");

      // R5 arm / disarm, R1 bit 3 and upper nibble
      simple_op(8'h06, "R5");
      rdsr(2, "R5 armed");
      simple_op(8'h04, "R5");
      rdsr(1, "R5 disarmed");
      simple_op(8'h0E, "R1");
      rdsr(1, "R1 bit3 ignored");
      simple_op(8'h04, "R5");
      frame_open(); send_hdr(8'h86, "R1"); frame_close();
      rdsr(1, "R1 upper nibble rejects opcode");

      // first write; busy and latch clear right after
      simple_op(8'h06, "R5");
      wr(16'h0010, 8, 8'h11, 8'h11, 0);
      rdsr(1, "R9 busy after commit");
      wait_idle();
      rdsr(1, "R9 busy ends");
      rd(16'h0010, 8, -1, "R3");
      rd(16'h8010, 3, -1, "R3 upper address bits ignored");

      // writes without latch
      wr(16'h0010, 2, 8'hAA, 1, 0);
      rd(16'h0010, 2, -1, "R6 array untouched");
      wrsr(8'h0C);
      rdsr(1, "R6 status untouched");

      // end-of-array wrap on read
      arm_write(16'h03FE, 2, 8'h3A, 1);
      arm_write(16'h0000, 2, 8'h5C, 1);
      rd(16'h03FE, 4, -1, "R3 wrap at array end");

      // page wrap and overwrite
      arm_write(16'h0020, 8, 8'h20, 1);
      arm_write(16'h0026, 4, 8'hC0, 3);
      rd(16'h0020, 8, -1, "R8 wrap inside page");
      arm_write(16'h0028, 10, 8'h70, 5);
      rd(16'h0028, 8, -1, "R8 later byte replaces earlier");

      // partial byte: no commit, latch kept
      simple_op(8'h06, "R5");
      wr(16'h0010, 1, 8'h55, 0, 3);
      rdsr(1, "R7 partial write keeps latch");
      rd(16'h0010, 1, -1, "R7 partial write dropped");

      // busy window: arm ignored, then read ignored
      wr(16'h0040, 1, 8'h99, 0, 0);
      simple_op(8'h06, "R10");
      wait_idle();
      rdsr(1, "R10 arm ignored while busy");
      simple_op(8'h06, "R5");
      wr(16'h0041, 1, 8'h9A, 0, 0);
      rd_busy();
      wait_idle();
      rd(16'h0040, 2, -1, "R9 committed bytes");

      // protection
      arm_write(16'h0300, 1, 8'h01, 0);
      arm_write(16'h0200, 1, 8'h02, 0);
      arm_write(16'h0100, 1, 8'h03, 0);
      simple_op(8'h06, "R5");
      wrsr(8'hF4);
      rdsr(1, "R13 status write busy");
      wait_idle();
      rdsr(1, "R13 only level bits stored");
      arm_write(16'h0300, 1, 8'hE1, 0);
      arm_write(16'h0200, 1, 8'hE2, 0);
      rd(16'h0300, 1, -1, "R11 top quarter locked");
      rd(16'h0200, 1, -1, "R11 below quarter writable");
      simple_op(8'h06, "R5"); wrsr(8'h08); wait_idle();
      arm_write(16'h0200, 1, 8'hF2, 0);
      arm_write(16'h0100, 1, 8'hF3, 0);
      rd(16'h0200, 1, -1, "R11 top half locked");
      rd(16'h0100, 1, -1, "R11 lower half writable");
      simple_op(8'h06, "R5"); wrsr(8'h0C); wait_idle();
      arm_write(16'h0100, 1, 8'h44, 0);
      rd(16'h0100, 1, -1, "R11 whole array locked");
      rdsr(1, "R11 latch cleared by dropped write");
      simple_op(8'h06, "R5"); wrsr(8'h00); wait_idle();
      rdsr(1, "R11 level cleared");

      // hold inside a read byte
      rd(16'h0010, 3, 1, "R12 hold resumes same bit");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule